// File: doc/BRIEF.md
# Programmable Receiver Backpressure Generator

This block sits in the receiving input port of a packet switch that holds four packet buffers. Each buffer raises a ready flag while it can take a new packet. The block counts the free buffers and drives one registered stop level back to the upstream sender. While the level is low the sender may begin new packets. While it is high the sender must not begin another one, although a packet already in flight is finished.

Three policies are available, and link length decides which one to use. The short-link policy raises stop only when no buffer is free. The long-link policy raises stop while one buffer or none is free, which leaves room for one packet that is already on the way. The refined long-link policy keeps the early threshold but holds back every rising edge by two cycles. Falling edges are never held back. When the free count climbs from zero to one, this policy also drops stop for exactly two cycles, so that one packet can be admitted into the single free buffer.

The policy is taken from a 2-bit configuration input. The block captures that input only in cycles where all four buffers are free, so a change cannot alter the policy in the middle of traffic.

Top module: `bp_stop_gen`

## Requirements
- R1: While `rst_n` is low, `stop_o` is 0, whatever the ready flags are. After reset the captured policy is short-link (code 00) and the block behaves as if all buffers were free.
- R2: Short-link policy (code 00): one cycle after any sampled ready pattern, `stop_o` is 1 if no ready flag was set, and 0 otherwise.
- R3: Long-link policy (code 01): one cycle after any sampled ready pattern, `stop_o` is 1 if at most one ready flag was set, and 0 otherwise. This includes a rise of the free count from zero to one, where stop stays high.
- R4: Refined policy (code 10): once the free count falls to at most one and stays there, `stop_o` rises three cycles after the first such sample. That is two cycles later than under the other policies.
- R5: Refined policy: if the free count returns to two or more before the delayed rise completes, `stop_o` does not rise.
- R6: Refined policy: one cycle after a sample that shows two or more free buffers, `stop_o` is 0, with no added delay.
- R7: Refined policy: when a sample shows one free buffer and the previous sample showed none, `stop_o` is 0 for exactly the next two cycles. After that it is 1 again if only one buffer is still free.
- R8: Refined policy: if the free count reaches two or more during that two-cycle opening, `stop_o` stays 0 after the opening.
- R9: The configuration input is captured only in cycles where all four ready flags are set. A change made while any buffer is occupied has no effect until the next such cycle.
- R10: Code 11 behaves exactly like the long-link policy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_ready | input | 4 | One flag per buffer; 1 means the buffer can take a packet |
| mode_cfg | input | 2 | Policy code: 00 short, 01 long, 10 refined, 11 long |
| stop_o | output | 1 | Registered stop level to the sender; 1 means begin no new packet |

## Verification
A broken free-count adder, or a wrong threshold, shows up as a wrong `stop_o` one cycle after the offending ready pattern. This happens under every policy.

A delay stage that is stuck or cleared at the wrong time makes the refined rise come one or more cycles early or late. It can also let the rise go through even after the condition has cleared. The bench can see this within three cycles of the free count dropping.

A wrong zero-history bit, or an off-by-one in the opening counter, changes how long stop stays low after a zero-to-one rise. It may stay low one cycle, three cycles, or not at all, and this is visible in the two cycles that follow the rise.

A policy register that loads while buffers are busy changes the stop level in mid-traffic. The bench can see this in the next cycle.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    POL_SHORT = 2'b00,
    POL_LONG  = 2'b01,
    POL_EARLY = 2'b10,
    POL_ALT   = 2'b11
  } bp_policy_e;
endpackage

// File: rtl/bp_free_count.sv
module bp_free_count #(
  parameter int NBUF = 4,
  parameter int CW   = $clog2(NBUF + 1)
) (
  input  logic [NBUF-1:0] ready_i,
  output logic [CW-1:0]   count_o
);
  always_comb begin
    count_o = '0;
    for (int i = 0; i < NBUF; i++) begin
      count_o = count_o + CW'(ready_i[i]);
    end
  end
endmodule

// File: rtl/bp_rise_delay.sv
module bp_rise_delay #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic ok_o
);
  logic [DEPTH-1:0] sh_q;
  logic [DEPTH-1:0] sh_d;

  always_comb begin
    sh_d[0] = req_i;
    for (int i = 1; i < DEPTH; i++) begin
      sh_d[i] = req_i & sh_q[i-1];
    end
  end

  assign ok_o = req_i & sh_q[DEPTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end
endmodule

// File: rtl/bp_credit_window.sv
module bp_credit_window #(
  parameter int LEN = 2,
  parameter int CW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] free_i,
  output logic          open_o
);
  localparam int LW = $clog2(LEN + 1);

  logic          zero_q;
  logic          zero_d;
  logic [LW-1:0] left_q;
  logic [LW-1:0] left_d;
  logic          trig;
  logic          active;

  assign trig   = zero_q & (free_i == CW'(1));
  assign active = (left_q != '0);
  assign open_o = trig | active;

  always_comb begin
    zero_d = (free_i == '0);
    if (trig) begin
      left_d = LW'(LEN - 1);
    end else if (active) begin
      left_d = left_q - LW'(1);
    end else begin
      left_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_q <= 1'b0;
      left_q <= '0;
    end else begin
      zero_q <= zero_d;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/bp_stop_gen.sv
module bp_stop_gen
  import bp_pkg::*;
#(
  parameter int NBUF       = 4,
  parameter int LONG_LIMIT = 1,
  parameter int RISE_DELAY = 2,
  parameter int OPEN_LEN   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NBUF-1:0] buf_ready,
  input  logic [1:0]      mode_cfg,
  output logic            stop_o
);
  localparam int CW = $clog2(NBUF + 1);

  logic [CW-1:0] free_cnt;
  logic          none_free;
  logic          few_free;
  logic          rise_ok;
  logic          win_open;
  logic          idle;
  logic          mode_en;
  bp_policy_e    mode_q;
  bp_policy_e    mode_d;
  logic          stop_q;
  logic          stop_d;

  bp_free_count #(.NBUF(NBUF), .CW(CW)) u_cnt (
    .ready_i (buf_ready),
    .count_o (free_cnt)
  );

  assign none_free = (free_cnt == '0);
  assign few_free  = (free_cnt <= CW'(LONG_LIMIT));
  assign idle      = &buf_ready;

  bp_rise_delay #(.DEPTH(RISE_DELAY)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (few_free),
    .ok_o  (rise_ok)
  );

  bp_credit_window #(.LEN(OPEN_LEN), .CW(CW)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .free_i (free_cnt),
    .open_o (win_open)
  );

  // policy capture only while every buffer is free
  assign mode_en = idle;
  always_comb begin
    mode_d = mode_q;
    if (mode_en) begin
      mode_d = bp_policy_e'(mode_cfg);
    end
  end

  always_comb begin
    unique case (mode_q)
      POL_SHORT: stop_d = none_free;
      POL_EARLY: stop_d = rise_ok & ~win_open;
      default:   stop_d = few_free;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= POL_SHORT;
      stop_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      stop_q <= stop_d;
    end
  end

  assign stop_o = stop_q;
endmodule

// File: rtl/bp_stop_gen_chk.sv
module bp_stop_gen_chk
  import bp_pkg::*;
#(
  parameter int NBUF       = 4,
  parameter int RISE_DELAY = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NBUF-1:0] buf_ready,
  input bp_policy_e      mode_q,
  input logic            stop_o
);
  logic few;
  logic [7:0] run_q;

  assign few = ($countones(buf_ready) <= 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!few) begin
      run_q <= '0;
    end else if (run_q != 8'hFF) begin
      run_q <= run_q + 8'd1;
    end
  end

  p_short_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == POL_SHORT) |=> (stop_o == $past(buf_ready == '0)));

  p_long_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == POL_LONG || mode_q == POL_ALT) |=> (stop_o == $past(few)));

  p_fast_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == POL_EARLY && !few) |=> !stop_o);

  p_delayed_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stop_o) && $past(mode_q) == POL_EARLY) |-> (run_q > 8'(RISE_DELAY)));

  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&buf_ready) |=> !stop_o);
endmodule

bind bp_stop_gen bp_stop_gen_chk #(.NBUF(NBUF), .RISE_DELAY(RISE_DELAY)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .buf_ready (buf_ready),
  .mode_q    (mode_q),
  .stop_o    (stop_o)
);

// File: tb/sim_bp_stop_gen.sv
`timescale 1ns/1ps
module sim_bp_stop_gen;
  logic       clk;
  logic       rst_n;
  logic [3:0] buf_ready;
  logic [1:0] mode_cfg;
  logic       stop_o;

  int n_chk;
  int n_fail;

  bp_stop_gen u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .buf_ready (buf_ready),
    .mode_cfg  (mode_cfg),
    .stop_o    (stop_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic exp);
    n_chk++;
    if (stop_o !== exp) begin
      n_fail++;
      $display("FAIL %s: stop_o=%b expected=%b at %0t", req, stop_o, exp, $time);
    end
  endtask

  task automatic go_idle(input logic [1:0] m);
    buf_ready = 4'b1111;
    mode_cfg  = m;
    tick(1);
  endtask

  task automatic t_reset_r1();
    buf_ready = 4'b0000;
    mode_cfg  = 2'b01;
    rst_n     = 1'b0;
    #1;
    check("R1", 1'b0);
    tick(3);
    check("R1", 1'b0);
    buf_ready = 4'b1111;
    mode_cfg  = 2'b00;
    rst_n     = 1'b1;
    tick(1);
    check("R1", 1'b0);
  endtask

  task automatic t_short_r2();
    go_idle(2'b00);
    buf_ready = 4'b0000; tick(1); check("R2", 1'b1);
    buf_ready = 4'b1000; tick(1); check("R2", 1'b0);
    buf_ready = 4'b0000; tick(1); check("R2", 1'b1);
    buf_ready = 4'b0110; tick(1); check("R2", 1'b0);
  endtask

  task automatic t_long_r3();
    go_idle(2'b01);
    buf_ready = 4'b0100; tick(1); check("R3", 1'b1);
    buf_ready = 4'b0101; tick(1); check("R3", 1'b0);
    buf_ready = 4'b0000; tick(1); check("R3", 1'b1);
    buf_ready = 4'b0010; tick(1); check("R3", 1'b1);
    tick(1);                      check("R3", 1'b1);
    buf_ready = 4'b1011; tick(1); check("R3", 1'b0);
  endtask

  task automatic t_rise_r4();
    go_idle(2'b10);
    buf_ready = 4'b0001;
    tick(1); check("R4", 1'b0);
    tick(1); check("R4", 1'b0);
    tick(1); check("R4", 1'b1);
  endtask

  task automatic t_abort_r5();
    go_idle(2'b10);
    buf_ready = 4'b1000;
    tick(1); check("R5", 1'b0);
    tick(1); check("R5", 1'b0);
    buf_ready = 4'b1100;
    tick(1); check("R5", 1'b0);
    tick(2); check("R5", 1'b0);
  endtask

  task automatic t_release_r6();
    go_idle(2'b10);
    buf_ready = 4'b0000;
    tick(3); check("R6", 1'b1);
    buf_ready = 4'b1100;
    tick(1); check("R6", 1'b0);
  endtask

  task automatic t_window_r7();
    go_idle(2'b10);
    buf_ready = 4'b0000;
    tick(4); check("R7", 1'b1);
    buf_ready = 4'b0010;
    tick(1); check("R7", 1'b0);
    tick(1); check("R7", 1'b0);
    tick(1); check("R7", 1'b1);
    tick(1); check("R7", 1'b1);
  endtask

  task automatic t_refill_r8();
    go_idle(2'b10);
    buf_ready = 4'b0000;
    tick(4); check("R8", 1'b1);
    buf_ready = 4'b0001;
    tick(1); check("R8", 1'b0);
    buf_ready = 4'b0011;
    tick(1); check("R8", 1'b0);
    tick(1); check("R8", 1'b0);
    tick(1); check("R8", 1'b0);
  endtask

  task automatic t_lock_r9();
    go_idle(2'b00);
    buf_ready = 4'b0001;
    tick(1); check("R9", 1'b0);
    mode_cfg = 2'b01;
    tick(1); check("R9", 1'b0);
    tick(1); check("R9", 1'b0);
    buf_ready = 4'b1111;
    tick(1); check("R9", 1'b0);
    buf_ready = 4'b0001;
    tick(1); check("R9", 1'b1);
  endtask

  task automatic t_alt_r10();
    go_idle(2'b11);
    buf_ready = 4'b1000; tick(1); check("R10", 1'b1);
    buf_ready = 4'b0000; tick(1); check("R10", 1'b1);
    buf_ready = 4'b0100; tick(1); check("R10", 1'b1);
    buf_ready = 4'b1001; tick(1); check("R10", 1'b0);
  endtask

  initial begin
    #100000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk  = 0;
    n_fail = 0;
    rst_n  = 1'b0;
    buf_ready = 4'b1111;
    mode_cfg  = 2'b00;
    @(negedge clk);
    t_reset_r1();
    t_short_r2();
    t_long_r3();
    t_rise_r4();
    t_abort_r5();
    t_release_r6();
    t_window_r7();
    t_refill_r8();
    t_lock_r9();
    t_alt_r10();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule